// File: doc/BRIEF.md
# Five-Stage In-Order Pipelined Datapath

This block is a 32-bit in-order core datapath split into five stages: fetch, decode with register read, execute, memory access and write-back. It runs a small load/store subset: word load, word store, five register-to-register ALU operations and branch-on-equal. Each stage owns one resource: the instruction port, the two register-file read ports, the ALU, the data port and the register-file write port. One instruction enters per cycle and one leaves per cycle.

There is no forwarding, no interlock and no stall. Every instruction passes through all five stages. ALU results wait one extra cycle so that they reach the single write port in stage 5, the same stage as loads. A branch resolves in the memory stage. Software sees three branch delay slots and a three-instruction load-use shadow. The instruction and data memories sit outside the block and answer in the same cycle.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `imem_addr` is 0 and `dmem_we` is 0. Reset loads no-op control into every stage register.
- R2: When no taken branch leaves the memory stage, `imem_addr` advances by 4 each cycle.
- R3: An instruction with bits [31:26]=0 is an ALU operation. Its fields are rs=[25:21], rt=[20:16] and rd=[15:11], and it writes register rd. The function code in bits [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. Any other function code does nothing.
- R4: Opcode 0x23 loads a word. It reads data memory at rs plus the sign-extended bits [15:0] and writes the word to register rt.
- R5: Opcode 0x2B stores a word. It drives `dmem_addr` = rs plus the sign-extended immediate, drives `dmem_wdata` = rt, and raises `dmem_we` for one cycle. That cycle is the third after the cycle in which the store was fetched. A store writes no register.
- R6: Opcode 0x04 compares rs with rt. If they are equal, the next fetch address becomes (branch address + 4) + (sign-extended immediate << 2). This fetch happens four cycles after the branch was fetched. The three sequential instructions that follow the branch always complete.
- R7: A branch on unequal operands does not change the sequential fetch order.
- R8: A register write takes effect at the end of write-back. The instruction fetched three slots after the writer reads the old value. The instruction fetched four slots after reads the new value.
- R9: Writes to register 0 are dropped, and register 0 always reads as 0.
- R10: An instruction with any other opcode writes neither a register nor data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | ADDR_W | Fetch byte address (registered PC) |
| imem_data | input | 32 | Instruction word for `imem_addr`, same cycle |
| dmem_addr | output | ADDR_W | Data byte address (registered) |
| dmem_wdata | output | DATA_W | Store data (registered) |
| dmem_we | output | 1 | Data write strobe (registered) |
| dmem_rdata | input | DATA_W | Load data for `dmem_addr`, same cycle |

## Verification
The bench builds the block with DATA_W=32 and ADDR_W=32. Both memories are modelled as 64-word arrays, which is enough to hold one fixed 46-instruction program. That program is run once for each of eight operand pairs, chosen to cover equal, unequal, negative, zero and extreme signed values. The bench computes every ALU result and both branch outcomes arithmetically. It also checks the fetch trace cycle by cycle, the delay-slot instructions, the old-versus-new register value across the load shadow, the dropped write to register 0, and the total number of data writes.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
  localparam logic [5:0] OPC_ALU   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam int RIDX_W = 5;

  typedef enum logic [2:0] {
    AOP_ADD = 3'd0,
    AOP_SUB = 3'd1,
    AOP_AND = 3'd2,
    AOP_OR  = 3'd3,
    AOP_SLT = 3'd4
  } aop_e;

  // All-zero value is the no-op encoding.
  typedef struct packed {
    logic reg_wr;
    logic mem_rd;
    logic mem_wr;
    logic branch;
    logic use_imm;
    aop_e aop;
  } ctl_t;
endpackage

// File: rtl/pipe_decode.sv
module pipe_decode
  import pipe_pkg::*;
(
  input  logic [31:0]       instr,
  output ctl_t              ctl,
  output logic [RIDX_W-1:0] dst
);
  logic [5:0] opc, fn;
  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    ctl = '0;
    dst = instr[15:11];
    unique case (opc)
      OPC_ALU: begin
        unique case (fn)
          FN_ADD:  begin ctl.reg_wr = 1'b1; ctl.aop = AOP_ADD; end
          FN_SUB:  begin ctl.reg_wr = 1'b1; ctl.aop = AOP_SUB; end
          FN_AND:  begin ctl.reg_wr = 1'b1; ctl.aop = AOP_AND; end
          FN_OR:   begin ctl.reg_wr = 1'b1; ctl.aop = AOP_OR;  end
          FN_SLT:  begin ctl.reg_wr = 1'b1; ctl.aop = AOP_SLT; end
          default: ctl = '0;
        endcase
      end
      OPC_LOAD: begin
        ctl.reg_wr = 1'b1; ctl.mem_rd = 1'b1; ctl.use_imm = 1'b1;
        dst = instr[20:16];
      end
      OPC_STORE: begin ctl.mem_wr = 1'b1; ctl.use_imm = 1'b1; end
      OPC_BEQ:   begin ctl.branch = 1'b1; ctl.aop = AOP_SUB; end
      default:   ctl = '0;
    endcase
  end
endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile #(
  parameter int DATA_W = 32,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) mem[waddr] <= wdata;
  end

  // Reads return the stored value; a same-cycle write is not bypassed.
  assign rdata_a = (raddr_a == '0) ? '0 : mem[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : mem[raddr_b];
endmodule

// File: rtl/pipe_alu.sv
module pipe_alu
  import pipe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aop_e              aop,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              zero
);
  always_comb begin
    unique case (aop)
      AOP_ADD: y = a + b;
      AOP_SUB: y = a - b;
      AOP_AND: y = a & b;
      AOP_OR:  y = a | b;
      AOP_SLT: y = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [31:0]       imem_data,
  output logic [ADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  output logic              dmem_we,
  input  logic [DATA_W-1:0] dmem_rdata
);
  localparam int EXT_W = DATA_W - 16;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  typedef struct packed {
    logic [ADDR_W-1:0] pc4;
    logic [31:0]       instr;
  } fd_t;

  typedef struct packed {
    ctl_t              ctl;
    logic [ADDR_W-1:0] pc4;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] imm;
    logic [RIDX_W-1:0] dst;
  } dx_t;

  typedef struct packed {
    ctl_t              ctl;
    logic              zero;
    logic [ADDR_W-1:0] target;
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] sdata;
    logic [RIDX_W-1:0] dst;
  } xm_t;

  typedef struct packed {
    ctl_t              ctl;
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] ldata;
    logic [RIDX_W-1:0] dst;
  } mw_t;

  logic [ADDR_W-1:0] pc_q;
  fd_t fd_q;
  dx_t dx_q;
  xm_t xm_q;
  mw_t mw_q;
  logic take_branch;

  // ---------------- fetch ----------------
  assign take_branch = xm_q.ctl.branch & xm_q.zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      fd_q <= '0;
    end else begin
      pc_q       <= take_branch ? xm_q.target : pc_q + STEP;
      fd_q.pc4   <= pc_q + STEP;
      fd_q.instr <= imem_data;
    end
  end
  assign imem_addr = pc_q;

  // ---------------- decode / register read ----------------
  ctl_t              id_ctl;
  logic [RIDX_W-1:0] id_dst;
  logic [DATA_W-1:0] rf_a, rf_b, wb_data;

  pipe_decode u_dec (
    .instr (fd_q.instr),
    .ctl   (id_ctl),
    .dst   (id_dst)
  );

  pipe_regfile #(.DATA_W(DATA_W), .AW(RIDX_W)) u_rf (
    .clk     (clk),
    .we      (mw_q.ctl.reg_wr),
    .waddr   (mw_q.dst),
    .wdata   (wb_data),
    .raddr_a (fd_q.instr[25:21]),
    .raddr_b (fd_q.instr[20:16]),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dx_q <= '0;
    end else begin
      dx_q.ctl <= id_ctl;
      dx_q.pc4 <= fd_q.pc4;
      dx_q.opa <= rf_a;
      dx_q.opb <= rf_b;
      dx_q.imm <= {{EXT_W{fd_q.instr[15]}}, fd_q.instr[15:0]};
      dx_q.dst <= id_dst;
    end
  end

  // ---------------- execute ----------------
  logic [DATA_W-1:0] alu_y;
  logic              alu_zero;

  pipe_alu #(.DATA_W(DATA_W)) u_alu (
    .aop  (dx_q.ctl.aop),
    .a    (dx_q.opa),
    .b    (dx_q.ctl.use_imm ? dx_q.imm : dx_q.opb),
    .y    (alu_y),
    .zero (alu_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xm_q <= '0;
    end else begin
      xm_q.ctl    <= dx_q.ctl;
      xm_q.zero   <= alu_zero;
      xm_q.target <= dx_q.pc4 + (dx_q.imm[ADDR_W-1:0] << 2);
      xm_q.res    <= alu_y;
      xm_q.sdata  <= dx_q.opb;
      xm_q.dst    <= dx_q.dst;
    end
  end

  // ---------------- memory ----------------
  assign dmem_addr  = xm_q.res[ADDR_W-1:0];
  assign dmem_wdata = xm_q.sdata;
  assign dmem_we    = xm_q.ctl.mem_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mw_q <= '0;
    end else begin
      mw_q.ctl   <= xm_q.ctl;
      mw_q.res   <= xm_q.res;
      mw_q.ldata <= dmem_rdata;
      mw_q.dst   <= xm_q.dst;
    end
  end

  // ---------------- write-back ----------------
  assign wb_data = mw_q.ctl.mem_rd ? mw_q.ldata : mw_q.res;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] imem_addr,
  input logic              dmem_we,
  input logic              redirect,
  input logic [ADDR_W-1:0] redirect_pc,
  input logic              ex_is_store,
  input logic              mem_branch,
  input logic              mem_zero
);
  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> imem_addr == '0);

  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> imem_addr == $past(imem_addr) + ADDR_W'(4));

  // R6
  redirect_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> imem_addr == $past(redirect_pc));

  // R7
  not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_branch && !mem_zero) |=> imem_addr == $past(imem_addr) + ADDR_W'(4));

  // R5
  store_origin_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> $past(ex_is_store));
endmodule

bind pipe5_core pipe5_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .imem_addr   (imem_addr),
  .dmem_we     (dmem_we),
  .redirect    (take_branch),
  .redirect_pc (xm_q.target),
  .ex_is_store (dx_q.ctl.mem_wr),
  .mem_branch  (xm_q.ctl.branch),
  .mem_zero    (xm_q.zero)
);

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;
  localparam int RUN_CYC = 56;
  localparam logic [31:0] SENT = 32'hDEADBEEF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] trace [RUN_CYC];
  logic        we_tr [RUN_CYC];
  int checks = 0;
  int fails  = 0;
  int wcount = 0;
  int cyc_total = 0;

  always #5 clk = ~clk;

  pipe5_core dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = (imem_addr < 32'd256) ? imem[imem_addr[7:2]] : 32'h0;
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (!rst && dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
      wcount = wcount + 1;
    end
  end

  always @(posedge clk) begin
    cyc_total = cyc_total + 1;
    if (cyc_total > 20000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc_total);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_alu(input int rd, input int rs, input int rt,
                                        input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] f_imm(input logic [5:0] op, input int rs,
                                        input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic load_program();
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    imem[0]  = f_imm(6'h23, 0, 1, 0);
    imem[1]  = f_imm(6'h23, 0, 2, 4);
    imem[5]  = f_alu(3, 1, 2, 6'h20);
    imem[6]  = f_alu(4, 1, 2, 6'h22);
    imem[7]  = f_alu(5, 1, 2, 6'h24);
    imem[8]  = f_alu(6, 1, 2, 6'h25);
    imem[9]  = f_alu(7, 1, 2, 6'h2A);
    imem[13] = f_imm(6'h2B, 0, 3, 16);
    imem[14] = f_imm(6'h2B, 0, 4, 20);
    imem[15] = f_imm(6'h2B, 0, 5, 24);
    imem[16] = f_imm(6'h2B, 0, 6, 28);
    imem[17] = f_imm(6'h2B, 0, 7, 32);
    imem[18] = f_imm(6'h04, 1, 2, 5);
    imem[19] = f_alu(8, 1, 0, 6'h20);
    imem[20] = f_alu(9, 2, 0, 6'h20);
    imem[22] = f_imm(6'h2B, 0, 1, 40);
    imem[24] = f_imm(6'h2B, 0, 2, 44);
    imem[25] = f_imm(6'h2B, 0, 8, 48);
    imem[26] = f_imm(6'h2B, 0, 9, 52);
    imem[27] = f_alu(0, 1, 1, 6'h20);
    imem[31] = f_imm(6'h2B, 0, 0, 56);
    imem[32] = f_alu(10, 0, 0, 6'h20);
    imem[36] = f_imm(6'h23, 0, 10, 4);
    imem[39] = f_imm(6'h2B, 0, 10, 60);
    imem[40] = f_imm(6'h2B, 0, 10, 64);
    imem[41] = f_imm(6'h3F, 0, 1, 4);
    imem[45] = f_imm(6'h2B, 0, 1, 68);
  endtask

  task automatic run_pair(input logic [31:0] a, input logic [31:0] b);
    logic taken;
    int bad;
    taken = (a == b);
    for (int i = 0; i < 64; i++) dmem[i] = SENT;
    dmem[0] = a;
    dmem[1] = b;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc in reset", imem_addr, 32'h0);
    chk("R1 no write in reset", {31'd0, dmem_we}, 32'h0);
    wcount = 0;
    rst = 1'b0;
    for (int c = 0; c < RUN_CYC; c++) begin
      trace[c] = imem_addr;
      we_tr[c] = dmem_we;
      @(negedge clk);
    end
    chk("R1 pc after reset", trace[0], 32'h0);
    bad = 0;
    for (int c = 1; c <= 22; c++) if (trace[c] != 32'(4 * c)) bad++;
    chk("R2 sequential fetch through delay slots", 32'(bad), 32'(taken ? 1 : 0));
    chk("R5 store strobe timing", {30'd0, we_tr[15], we_tr[16]}, 32'h1);
    chk("R6/R7 fetch after delay slots", trace[22], taken ? 32'd96 : 32'd88);
    chk("R3 add", dmem[4], a + b);
    chk("R3 sub", dmem[5], a - b);
    chk("R3 and", dmem[6], a & b);
    chk("R3 or",  dmem[7], a | b);
    chk("R3 slt", dmem[8], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
    chk("R7 fall-through store", dmem[10], taken ? SENT : a);
    chk("R6 target store", dmem[11], b);
    chk("R6 delay slot 1", dmem[12], a);
    chk("R6 delay slot 2", dmem[13], b);
    chk("R9 register 0 stays zero", dmem[14], 32'h0);
    chk("R8 third slot sees old value", dmem[15], 32'h0);
    chk("R8 R4 fourth slot sees loaded value", dmem[16], b);
    chk("R10 unknown opcode leaves register", dmem[17], a);
    chk("R10 R5 total data writes", 32'(wcount), taken ? 32'd12 : 32'd13);
  endtask

  initial begin
    load_program();
    run_pair(32'd5, 32'd7);
    run_pair(32'd7, 32'd5);
    run_pair(32'hFFFF_FFFD, 32'd4);
    run_pair(32'd4, 32'hFFFF_FFFD);
    run_pair(32'd9, 32'd9);
    run_pair(32'd0, 32'd0);
    run_pair(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_pair(32'h7FFF_FFFF, 32'hFFFF_FFFF);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule